// File: doc/BRIEF.md
# Three-Operand Conditional Move Cracker

This decode-stage block turns a conditional move with three register operands into two dependent micro-ops that each read only two sources. The rename stage and the execution datapaths behind it then never see a third source. A conditional move writes one of two values into its destination: either the value register or the old contents of the destination. The condition register picks which one.

The cracked pair uses the old destination as an explicit source. The first micro-op is a select step. It reads the condition register and the old destination, evaluates the condition (named by the low opcode bits) and writes its result into a temporary copy of the destination. The second micro-op is a merge step. It reads that temporary and the value register and writes the final destination, so the same architectural destination is renamed twice.

Every other instruction passes through as a single micro-op with its fields unchanged. Both sides use a valid/ready handshake. A conditional move stays at the input and is consumed only when its second micro-op is accepted. This lets the block hold just one phase bit.

Top module: `cmov_cracker`

## Requirements
- R1: After reset, and whenever `in_valid` is low, `out_valid` is low; with `out_ready` high and no pair in progress, `in_ready` is high.
- R2: An instruction whose opcode is not a conditional move leaves as one micro-op of kind PASS (`out_kind` = 2'b00) in the same cycle. It carries `out_opc` = `in_opc`, `out_src_a` = `in_ra`, `out_src_b` = `in_rb` and `out_dst` = `in_rc`, with both temporary flags low, and `in_ready` equals `out_ready`.
- R3: The first micro-op of a conditional move has kind SEL (2'b01). It carries `out_src_a` = `in_ra` (condition register), `out_src_b` = `in_rc` (old destination) and `out_dst` = `in_rc` with `out_dst_tmp` high, `out_src_a_tmp` low and `out_opc` = `in_opc`. While it is offered, `in_ready` is low.
- R4: The handshake after the first micro-op is accepted offers kind MERGE (2'b10). It carries `out_src_a` = `in_rc` with `out_src_a_tmp` high (the temporary), `out_src_b` = `in_rb` (value register) and `out_dst` = `in_rc` with `out_dst_tmp` low, and `out_opc` carries the same opcode.
- R5: A conditional move is consumed from the input (`in_ready` high) only in the cycle its MERGE micro-op is accepted.
- R6: While `out_valid` is high and `out_ready` is low, the offered micro-op stays valid and unchanged in every field, including in the middle of a pair.
- R7: An opcode is a conditional move when `(in_opc & CMOV_MASK) == CMOV_BASE`. With the defaults (6-bit opcodes, mask 6'h38, base 6'h18), opcodes 6'h18 to 6'h1F are cracked and 6'h17 and 6'h20 pass through.
- R8: After a MERGE is accepted, the next instruction is handled from its first step. This holds both when it arrives in the very next cycle and when it arrives after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction consumed this cycle |
| in_opc | input | OPC_W | Decoded opcode |
| in_ra | input | REG_W | Condition / first source register |
| in_rb | input | REG_W | Value / second source register |
| in_rc | input | REG_W | Destination register |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Micro-op accepted when high with `out_valid` |
| out_kind | output | 2 | PASS 00, SEL 01, MERGE 10 |
| out_opc | output | OPC_W | Opcode carried on the micro-op |
| out_src_a | output | REG_W | First source register |
| out_src_a_tmp | output | 1 | First source is the internal temporary |
| out_src_b | output | REG_W | Second source register |
| out_dst | output | REG_W | Destination register |
| out_dst_tmp | output | 1 | Destination is the internal temporary |

## Verification
The assertions assume the upstream source obeys the valid/ready rule. Once `in_valid` is raised, the instruction and its fields stay fixed until `in_ready` is seen high. The stall-stability and pair-ordering properties depend on this, because the offered micro-op is formed from the held input.

The bench drives inputs only at falling edges. It changes the instruction only after a cycle in which it saw `in_ready` high, and it never drops `in_valid` in the middle of a pair. This holds even when `out_ready` is pulled low between the SEL and MERGE steps.

// File: rtl/cmvx_pkg.sv
package cmvx_pkg;
  localparam int KIND_W = 2;
  localparam logic [KIND_W-1:0] KIND_PASS  = 2'b00;
  localparam logic [KIND_W-1:0] KIND_SEL   = 2'b01;
  localparam logic [KIND_W-1:0] KIND_MERGE = 2'b10;
endpackage

// File: rtl/cmvx_rst_sync.sv
module cmvx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmvx_decode.sv
module cmvx_decode #(
  parameter int           OPC_W     = 6,
  parameter logic [5:0]   CMOV_MASK = 6'h38,
  parameter logic [5:0]   CMOV_BASE = 6'h18
) (
  input  logic [OPC_W-1:0] opc,
  output logic             is_cmov
);
  localparam logic [OPC_W-1:0] MASK_W = OPC_W'(CMOV_MASK);
  localparam logic [OPC_W-1:0] BASE_W = OPC_W'(CMOV_BASE);

  always_comb begin
    is_cmov = ((opc & MASK_W) == BASE_W);
  end
endmodule

// File: rtl/cmvx_phase.sv
module cmvx_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic is_cmov,
  output logic second_q
);
  logic second_d;
  logic phase_en;

  always_comb begin
    phase_en = in_valid & out_ready;
    second_d = is_cmov & ~second_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        second_q <= 1'b0;
    else if (phase_en) second_q <= second_d;
  end

  AST_PHASE_ONLY_CMOV: assert property (@(posedge clk) disable iff (!rst_n)
    second_q |-> in_valid && is_cmov) else $error("phase set without cmov"); // R4
endmodule

// File: rtl/cmvx_build.sv
module cmvx_build
  import cmvx_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int REG_W = 5
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [REG_W-1:0]  ra,
  input  logic [REG_W-1:0]  rb,
  input  logic [REG_W-1:0]  rc,
  input  logic              is_cmov,
  input  logic              second,
  output logic [KIND_W-1:0] kind,
  output logic [OPC_W-1:0]  u_opc,
  output logic [REG_W-1:0]  src_a,
  output logic              src_a_tmp,
  output logic [REG_W-1:0]  src_b,
  output logic [REG_W-1:0]  dst,
  output logic              dst_tmp
);
  always_comb begin
    u_opc     = opc;
    kind      = KIND_PASS;
    src_a     = ra;
    src_a_tmp = 1'b0;
    src_b     = rb;
    dst       = rc;
    dst_tmp   = 1'b0;
    if (is_cmov) begin
      if (!second) begin
        kind    = KIND_SEL;
        src_a   = ra;
        src_b   = rc;
        dst_tmp = 1'b1;
      end else begin
        kind      = KIND_MERGE;
        src_a     = rc;
        src_a_tmp = 1'b1;
        src_b     = rb;
      end
    end
  end
endmodule

// File: rtl/cmov_cracker.sv
module cmov_cracker
  import cmvx_pkg::*;
#(
  parameter int         OPC_W     = 6,
  parameter int         REG_W     = 5,
  parameter logic [5:0] CMOV_MASK = 6'h38,
  parameter logic [5:0] CMOV_BASE = 6'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opc,
  input  logic [REG_W-1:0]  in_ra,
  input  logic [REG_W-1:0]  in_rb,
  input  logic [REG_W-1:0]  in_rc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [OPC_W-1:0]  out_opc,
  output logic [REG_W-1:0]  out_src_a,
  output logic              out_src_a_tmp,
  output logic [REG_W-1:0]  out_src_b,
  output logic [REG_W-1:0]  out_dst,
  output logic              out_dst_tmp
);
  logic rst_sync_n;
  logic is_cmov;
  logic second_q;

  cmvx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cmvx_decode #(.OPC_W(OPC_W), .CMOV_MASK(CMOV_MASK), .CMOV_BASE(CMOV_BASE)) u_dec (
    .opc(in_opc), .is_cmov(is_cmov)
  );

  cmvx_phase u_phase (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .out_ready(out_ready),
    .is_cmov(is_cmov), .second_q(second_q)
  );

  cmvx_build #(.OPC_W(OPC_W), .REG_W(REG_W)) u_build (
    .opc(in_opc), .ra(in_ra), .rb(in_rb), .rc(in_rc),
    .is_cmov(is_cmov), .second(second_q),
    .kind(out_kind), .u_opc(out_opc), .src_a(out_src_a), .src_a_tmp(out_src_a_tmp),
    .src_b(out_src_b), .dst(out_dst), .dst_tmp(out_dst_tmp)
  );

  always_comb begin
    out_valid = in_valid;
    in_ready  = out_ready & (~is_cmov | second_q);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid) else $error("valid without input"); // R1
  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KIND_PASS |-> in_ready == out_ready) else $error("pass not single"); // R2
  AST_SEL_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_kind == KIND_SEL |-> !in_ready && out_dst_tmp) else $error("sel consumed input"); // R3
  AST_MERGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_kind == KIND_SEL |=> out_valid && out_kind == KIND_MERGE)
    else $error("merge missing"); // R4
  AST_CONSUME_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_kind != KIND_PASS |-> out_kind == KIND_MERGE) else $error("early consume"); // R5
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_src_a)
      && $stable(out_src_b) && $stable(out_dst) && $stable(out_opc)) else $error("stall changed uop"); // R6
  AST_MERGE_THEN_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_kind == KIND_MERGE |=> out_kind != KIND_MERGE) else $error("phase not reset"); // R8
endmodule

// File: tb/cmov_cracker_test.sv
module cmov_cracker_test;
  localparam int OPC_W = 6;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [OPC_W-1:0] in_opc = '0;
  logic [REG_W-1:0] in_ra = '0, in_rb = '0, in_rc = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [OPC_W-1:0] out_opc;
  logic [REG_W-1:0] out_src_a, out_src_b, out_dst;
  logic out_src_a_tmp, out_dst_tmp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmov_cracker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc(in_opc), .in_ra(in_ra), .in_rb(in_rb), .in_rc(in_rc),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_opc(out_opc), .out_src_a(out_src_a), .out_src_a_tmp(out_src_a_tmp),
    .out_src_b(out_src_b), .out_dst(out_dst), .out_dst_tmp(out_dst_tmp)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit v, bit ordy, logic [OPC_W-1:0] op,
                       logic [REG_W-1:0] a, logic [REG_W-1:0] b, logic [REG_W-1:0] c);
    @(negedge clk);
    in_valid = v; out_ready = ordy; in_opc = op; in_ra = a; in_rb = b; in_rc = c;
    #1;
  endtask

  task automatic check_uop(string req, int kind, int op, int sa, int sat,
                           int sb, int d, int dt, int irdy);
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "out_kind", int'(out_kind), kind);
    check(req, "out_opc", int'(out_opc), op);
    check(req, "out_src_a", int'(out_src_a), sa);
    check(req, "out_src_a_tmp", int'(out_src_a_tmp), sat);
    check(req, "out_src_b", int'(out_src_b), sb);
    check(req, "out_dst", int'(out_dst), d);
    check(req, "out_dst_tmp", int'(out_dst_tmp), dt);
    check(req, "in_ready", int'(in_ready), irdy);
  endtask

  task automatic send_pass(string req, int op, int a, int b, int c);
    drive(1'b1, 1'b1, OPC_W'(op), REG_W'(a), REG_W'(b), REG_W'(c));
    check_uop(req, 0, op, a, 0, b, c, 0, 1);
  endtask

  task automatic send_cmov(string req, int op, int a, int b, int c);
    drive(1'b1, 1'b1, OPC_W'(op), REG_W'(a), REG_W'(b), REG_W'(c));
    check_uop({req, "/R3"}, 1, op, a, 0, c, c, 1, 0);
    drive(1'b1, 1'b1, OPC_W'(op), REG_W'(a), REG_W'(b), REG_W'(c));
    check_uop({req, "/R4"}, 2, op, c, 1, b, c, 0, 1);
  endtask

  task automatic t_reset;
    drive(1'b0, 1'b1, '0, '0, '0, '0);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "in_ready", int'(in_ready), 1);
  endtask

  task automatic t_pass;
    send_pass("R2", 6'h05, 3, 7, 9);
    send_pass("R2", 6'h3F, 31, 0, 17);
  endtask

  task automatic t_cmov;
    send_cmov("R5", 6'h1A, 4, 12, 20);
  endtask

  task automatic t_stall_mid;
    drive(1'b1, 1'b1, 6'h1C, 2, 6, 11);
    check_uop("R3", 1, 6'h1C, 2, 0, 11, 11, 1, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 6'h1C, 2, 6, 11);
      check_uop("R6", 2, 6'h1C, 11, 1, 6, 11, 0, 0);
    end
    drive(1'b1, 1'b1, 6'h1C, 2, 6, 11);
    check_uop("R5", 2, 6'h1C, 11, 1, 6, 11, 0, 1);
  endtask

  task automatic t_stall_first;
    for (int i = 0; i < 2; i++) begin
      drive(1'b1, 1'b0, 6'h19, 8, 9, 10);
      check_uop("R6", 1, 6'h19, 8, 0, 10, 10, 1, 0);
    end
    send_cmov("R6", 6'h19, 8, 9, 10);
  endtask

  task automatic t_mix;
    send_pass("R7", 6'h17, 1, 2, 3);
    send_cmov("R7", 6'h18, 5, 6, 7);
    send_cmov("R8", 6'h1F, 13, 14, 15);
    send_pass("R7", 6'h20, 21, 22, 23);
    send_cmov("R8", 6'h1B, 24, 25, 26);
  endtask

  task automatic t_idle_gap;
    send_cmov("R8", 6'h1D, 27, 28, 29);
    drive(1'b0, 1'b1, '0, '0, '0, '0);
    check("R1", "out_valid", int'(out_valid), 0);
    drive(1'b0, 1'b1, '0, '0, '0, '0);
    send_cmov("R8", 6'h1E, 30, 1, 2);
    send_pass("R8", 6'h00, 3, 4, 5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);
        t_reset();
        t_pass();
        t_cmov();
        t_stall_mid();
        t_stall_first();
        t_mix();
        t_idle_gap();
        drive(1'b0, 1'b1, '0, '0, '0, '0);
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule